// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock, and the two clocks may run at any rates with respect to each other. Both pointers cross the domain boundary in Gray code through two-flop synchronizers, so every status flag is conservative: it can report a fill level that is briefly stale in the safe direction, but never a wrong one.

The output timing is chosen once, while master reset is held. In standard mode a word stays hidden until a read is requested, the read-side flag means "empty" and the write-side flag means "full". In fall-through mode the oldest word is moved to the output register without a request, the read-side flag means "output holds a valid word" and the write-side flag means "room for another word". A read chip select, sampled on the read clock, masks read requests and drives a flag that tells the pad logic to float the data bus. A half-full flag is available in both modes. Master reset clears data and re-latches the mode; partial reset clears data only.

Top module: `xclk_fifo`

## Requirements
- R1: Every word accepted on a write clock edge (wr_en high, not full) is returned on rd_data exactly once, in the order written.
- R2: In standard mode (mode latched 0), rd_flag is 1 when the storage array holds no word and wr_flag is 1 when it holds DEPTH words; rd_data changes only on a read clock edge where rd_en and rd_cs are both 1 and a word is present.
- R3: In fall-through mode (mode latched 1), rd_flag is 1 while rd_data holds a valid unread word and wr_flag is 1 while the array has room; a word written to an empty FIFO appears on rd_data, with rd_flag set, at the third read clock rising edge after the write edge, with no rd_en.
- R4: The mode is taken from mode_sel on read clock edges while mrst_n is 0; changes of mode_sel at other times have no effect.
- R5: A write while the array is full is dropped, and a read request while nothing is available leaves rd_data and the flags unchanged.
- R6: On a read clock edge with rd_cs at 0, rd_en is ignored and rd_data_hiz becomes 1 after that edge; with rd_cs at 1 it becomes 0.
- R7: half_full is 1 when the storage array holds more than DEPTH/2 words; in fall-through mode the word held in the output register is not counted.
- R8: Master reset empties the FIFO, sets rd_data to 0 and rd_data_hiz to 0, and leaves the flags in the empty state of the latched mode.
- R9: Partial reset empties the FIFO and sets rd_data to 0 but keeps the mode latched by the last master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous; mode is captured while low |
| prst_n | input | 1 | Partial reset, active low, asynchronous; keeps the mode |
| mode_sel | input | 1 | Timing mode request: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write data |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |
| rd_en | input | 1 | Read request |
| rd_cs | input | 1 | Read chip select, active high, sampled on rd_clk |
| rd_data | output | W | Read data register |
| rd_data_hiz | output | 1 | Data bus should be floated |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |

## Verification
The bench sweeps every fill level from empty to full in both modes, using a distinct data pattern per level, so that flag thresholds (empty, full, the half-full boundary at DEPTH/2 and DEPTH/2+1) and the extra output stage of fall-through mode are each tested at the exact level where they switch. Writes past full and reads past empty show that overflow and underflow are dropped rather than wrapping the pointers. A read with chip select low, held against a non-empty FIFO, separates request masking from ordinary reading, and a single write to an empty fall-through FIFO measures the three-edge latency. Changing mode_sel after reset and issuing partial resets show that the mode is held until the next master reset.

// File: rtl/xcf_pkg.sv
package xcf_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  // Distance between two wrapping pointers of pw bits.
  function automatic logic [31:0] occupancy(input logic [31:0] wb, input logic [31:0] rb,
                                            input int pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (wb - rb) & mask;
  endfunction

endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xcf_wctl.sv
module xcf_wctl #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          wr_fire,
  output logic          half_full
);
  import xcf_pkg::*;

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wbin_nxt;
  logic [31:0]   occ;

  assign rbin_s    = PW'(gray2bin(32'(rgray_s)));
  assign occ       = occupancy(32'(wbin), 32'(rbin_s), PW);
  assign full      = (occ == 32'(DEPTH));
  assign half_full = (occ > 32'(DEPTH / 2));
  assign wr_fire   = wr_en & ~full;
  assign wbin_nxt  = wbin + PW'(1);
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bin2gray(32'(wbin_nxt)));
    end
  end
endmodule

// File: rtl/xcf_rctl.sv
module xcf_rctl #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          ft_mode,
  input  logic          rd_en,
  input  logic          rd_cs,
  input  logic [PW-1:0] wgray_s,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic [W-1:0]  rd_data,
  output logic          rd_data_hiz,
  output logic          rd_flag,
  output logic          pop
);
  import xcf_pkg::*;

  logic          mem_empty;
  logic          rd_req;
  logic          out_valid;
  logic [PW-1:0] rbin_nxt;

  assign mem_empty = (rgray == wgray_s);
  assign rd_req    = rd_en & rd_cs;
  // Standard mode pops only on request; fall-through also refills an idle output stage.
  assign pop       = ~mem_empty & (ft_mode ? (~out_valid | rd_req) : rd_req);
  assign rbin_nxt  = rbin + PW'(1);
  assign raddr     = rbin[AW-1:0];
  assign rd_flag   = ft_mode ? out_valid : mem_empty;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      rd_data   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (pop) begin
        rbin    <= rbin_nxt;
        rgray   <= PW'(bin2gray(32'(rbin_nxt)));
        rd_data <= mem_rdata;
      end
      if (pop)         out_valid <= 1'b1;
      else if (rd_req) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rd_data_hiz <= 1'b0;
    else        rd_data_hiz <= ~rd_cs;
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         mode_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         wr_flag,
  output logic         half_full,
  input  logic         rd_en,
  input  logic         rd_cs,
  output logic [W-1:0] rd_data,
  output logic         rd_data_hiz,
  output logic         rd_flag
);
  logic          rst_all_n;
  logic          ft_mode;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wgray_s, rgray_s;
  logic          full, wr_fire, pop;
  logic [W-1:0]  mem [DEPTH];

  assign rst_all_n = mrst_n & prst_n;

  // Mode is captured while master reset is held and is static afterwards.
  always_ff @(posedge rd_clk) begin
    if (!mrst_n) ft_mode <= mode_sel;
  end

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  xcf_wctl #(.DEPTH(DEPTH)) u_wctl (
    .wr_clk(wr_clk), .rst_n(rst_all_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .waddr(waddr), .wbin(wbin), .wgray(wgray), .full(full),
    .wr_fire(wr_fire), .half_full(half_full)
  );

  xcf_sync #(.WIDTH(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_all_n), .d(rgray), .q(rgray_s));
  xcf_sync #(.WIDTH(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_all_n), .d(wgray), .q(wgray_s));

  xcf_rctl #(.W(W), .DEPTH(DEPTH)) u_rctl (
    .rd_clk(rd_clk), .rst_n(rst_all_n), .ft_mode(ft_mode), .rd_en(rd_en),
    .rd_cs(rd_cs), .wgray_s(wgray_s), .mem_rdata(mem[raddr]), .raddr(raddr),
    .rbin(rbin), .rgray(rgray), .rd_data(rd_data), .rd_data_hiz(rd_data_hiz),
    .rd_flag(rd_flag), .pop(pop)
  );

  assign wr_flag = ft_mode ? ~full : full;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter  int W     = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_all_n,
  input logic          ft_mode,
  input logic          rd_en,
  input logic          rd_cs,
  input logic [W-1:0]  rd_data,
  input logic          rd_data_hiz,
  input logic          rd_flag,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rgray_s,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray_s
);
  import xcf_pkg::*;

  logic [31:0] wocc, rocc;
  assign wocc = occupancy(32'(wbin), gray2bin(32'(rgray_s)), PW);
  assign rocc = occupancy(gray2bin(32'(wgray_s)), 32'(rbin), PW);

  // R5: write-side view never exceeds capacity (overflow is dropped)
  assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!rst_all_n)
    wocc <= 32'(DEPTH));

  // R5: read-side view never exceeds capacity (underflow would wrap it)
  assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    rocc <= 32'(DEPTH));

  // R2: standard mode read pointer moves only on a selected request
  assert_std_rd_gated_R2: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    (!ft_mode && !(rd_en && rd_cs)) |=> $stable(rbin));

  // R2: standard mode, empty FIFO holds the output word
  assert_std_empty_hold_R2: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    (!ft_mode && rd_flag) |=> $stable(rd_data));

  // R3: fall-through mode keeps a ready word until it is consumed
  assert_ft_hold_R3: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    (ft_mode && rd_flag && !(rd_en && rd_cs)) |=> (rd_flag && $stable(rd_data)));

  // R6: deselected read port floats the bus after the edge
  assert_cs_hiz_R6: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    !rd_cs |=> rd_data_hiz);
endmodule

bind xclk_fifo xclk_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_all_n(rst_all_n), .ft_mode(ft_mode),
  .rd_en(rd_en), .rd_cs(rd_cs), .rd_data(rd_data), .rd_data_hiz(rd_data_hiz),
  .rd_flag(rd_flag), .wbin(wbin), .rgray_s(rgray_s), .rbin(rbin), .wgray_s(wgray_s)
);

// File: tb/tb_xclk_fifo.sv
`timescale 1ns/100ps
module tb_xclk_fifo;
  localparam int W = 8;
  localparam int DEPTH = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rd_cs = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic wr_flag, half_full, rd_data_hiz, rd_flag;
  logic [W-1:0] rd_data;

  int n_cmp = 0, n_bad = 0;

  xclk_fifo #(.W(W), .DEPTH(DEPTH)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
    .half_full(half_full), .rd_en(rd_en), .rd_cs(rd_cs), .rd_data(rd_data),
    .rd_data_hiz(rd_data_hiz), .rd_flag(rd_flag)
  );

  // 200 MHz write clock; read clock 7 ns, offset so edges never coincide.
  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #0.3;
    forever #3.5 rd_clk = ~rd_clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic master_reset(input logic m);
    mode_sel = m;
    mrst_n = 1'b0;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk) mrst_n = 1'b1;
  endtask

  task automatic partial_reset();
    prst_n = 1'b0;
    repeat (2) @(posedge rd_clk);
    @(negedge wr_clk) prst_n = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  function automatic logic [W-1:0] pat(input int k, input int i);
    return W'(k * 37 + i * 5 + 3);
  endfunction

  task automatic write_burst(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = pat(k, i);
    end
    @(negedge wr_clk) wr_en = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge rd_clk) rd_en = 1'b1;
    @(negedge rd_clk) rd_en = 1'b0;
  endtask

  initial begin
    #500us;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    // ---------------- standard mode ----------------
    master_reset(1'b0);
    mode_sel = 1'b1;  // R4: ignored outside master reset
    @(negedge rd_clk);
    check("R8 reset empty flag", 32'(rd_flag), 1);
    check("R8 reset full flag", 32'(wr_flag), 0);
    check("R8 reset half_full", 32'(half_full), 0);
    check("R8 reset rd_data", 32'(rd_data), 0);
    check("R8 reset hiz", 32'(rd_data_hiz), 0);

    for (int k = 0; k <= DEPTH; k++) begin
      partial_reset();  // R9: mode kept
      write_burst(k, k);
      if (k == DEPTH) write_burst(99, 1);  // R5: dropped
      settle();
      check("R2/R4/R9 empty flag", 32'(rd_flag), 32'(k == 0));
      check("R2 full flag", 32'(wr_flag), 32'(k == DEPTH));
      check("R7 half_full", 32'(half_full), 32'(k > DEPTH / 2));
      check("R2 no read no output", 32'(rd_data), 0);
      if (k > 0) begin
        @(negedge rd_clk) begin rd_cs = 1'b0; rd_en = 1'b1; end
        @(negedge rd_clk) begin rd_cs = 1'b1; rd_en = 1'b0; end
        check("R6 masked read", 32'(rd_data), 0);
        check("R6 hiz set", 32'(rd_data_hiz), 1);
      end
      for (int i = 0; i < k; i++) begin
        pop_one();
        check("R1 std order", 32'(rd_data), 32'(pat(k, i)));
      end
      check("R6 hiz clear", 32'(rd_data_hiz), 0);
      settle();
      check("R2 empty after drain", 32'(rd_flag), 1);
      check("R7 half_full after drain", 32'(half_full), 0);
      if (k > 0) begin
        pop_one();  // R5 underflow
        check("R5 underflow data held", 32'(rd_data), 32'(pat(k, k - 1)));
        check("R5 underflow flag", 32'(rd_flag), 1);
      end
    end

    // ---------------- fall-through mode ----------------
    master_reset(1'b1);
    @(negedge rd_clk);
    check("R8 ft reset ready", 32'(rd_flag), 0);
    check("R8 ft reset input-ready", 32'(wr_flag), 1);
    check("R8 ft reset rd_data", 32'(rd_data), 0);
    mode_sel = 1'b0;  // R4: ignored

    @(negedge wr_clk) begin wr_en = 1'b1; wr_data = 8'hA5; end
    @(posedge wr_clk) wr_en <= 1'b0;
    n = 0;
    do begin
      @(posedge rd_clk) n++;
      @(negedge rd_clk);
    end while (!rd_flag && n < 10);
    check("R3 fall-through latency", 32'(n), 3);
    check("R3 fall-through data", 32'(rd_data), 32'h A5);
    pop_one();
    check("R3 ready clears", 32'(rd_flag), 0);
    pop_one();  // R5 underflow in fall-through
    check("R5 ft underflow data held", 32'(rd_data), 32'h A5);

    for (int k = 1; k <= DEPTH + 1; k++) begin
      partial_reset();
      write_burst(k, k);
      if (k == DEPTH + 1) write_burst(99, 1);  // R5: dropped
      settle();
      check("R3/R4/R9 ready", 32'(rd_flag), 1);
      check("R3 input-ready", 32'(wr_flag), 32'(k != DEPTH + 1));
      check("R7 ft half_full", 32'(half_full), 32'((k - 1) > DEPTH / 2));
      if (k == 2) begin
        @(negedge rd_clk) begin rd_cs = 1'b0; rd_en = 1'b1; end
        @(negedge rd_clk) begin rd_cs = 1'b1; rd_en = 1'b0; end
        check("R6 ft masked read", 32'(rd_data), 32'(pat(k, 0)));
      end
      for (int i = 0; i < k; i++) begin
        check("R1 ft order", 32'(rd_data), 32'(pat(k, i)));
        pop_one();
      end
      settle();
      check("R3 not ready after drain", 32'(rd_flag), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule